// File: doc/BRIEF.md
# Serial-Fed Quadrature Position Counters

This block tracks the motion of two pointing controllers whose quadrature lines reach the chip through an external parallel-to-serial shift register. It drives that register with a one-cycle capture strobe and then a train of shift clock pulses. It samples one data bit on each rising shift clock edge and builds a 16-bit frame from them. When the frame is complete, the block updates four position values at once: horizontal and vertical for each of the two ports. It also keeps the eight trailing frame bits as a general control byte.

Each position value is eight bits. The upper six bits count up or down as the quadrature pair moves. The lower two bits follow the live state of the pair in Gray form, so software can also read the same word as a four-way digital joystick. A decoded direction nibble per port is provided for that use. A single test-write port loads the six-bit counters of all four positions in one cycle.

Top module: `mouse_quad_ctr`

## Requirements
- R1: While `rst_n` is low at a clock edge, both port words, both direction nibbles and the control byte are zero, and `ser_ld_o` and `ser_clk_o` are low.
- R2: A frame is a one-cycle high pulse on `ser_ld_o`, followed by 16 shift clock pulses, each `SCLK_HALF` cycles low then `SCLK_HALF` cycles high, followed at once by the next capture pulse (65 cycles per frame at the default). `ser_clk_o` is never high while `ser_ld_o` is high.
- R3: `ser_dat_i` is sampled at the clock edge where `ser_clk_o` rises. The first bit sampled is frame bit 0. Frame bits 0..7 are port0 horizontal main, port0 horizontal quadrature, port0 vertical main, port0 vertical quadrature, and then the same four for port1.
- R4: Each port word holds the vertical position in bits 15..8 and the horizontal position in bits 7..0.
- R5: One clock after the 16th shift clock rise, the two low bits of each position become {quadrature, main XOR quadrature} of that axis's sampled pair.
- R6: In that same update, a low-bit change from 3 to 0 adds one to the axis's six-bit counter, and a change from 0 to 3 subtracts one. Any other change leaves the counter alone.
- R7: The six-bit counters wrap modulo 64 in both directions.
- R8: A change of two steps in one frame (0↔2 or 1↔3 in the low bits) updates the low bits but not the six-bit counter.
- R9: When `tst_we_i` is high at a clock edge, every vertical counter takes `tst_dat_i[15:10]` and every horizontal counter takes `tst_dat_i[7:2]`. Data bits 9..8 and 1..0 have no effect, and the low two bits of every position keep their values.
- R10: If a test write and a frame update fall on the same edge, the test data wins for the six-bit counters, and the low bits still take the new frame's pair state.
- R11: At each frame update, `ctrl_byte_o` takes frame bits 15..8, with frame bit 8 in bit 0.
- R12: Each direction nibble is {right, back, left, forward} of its port word w, where forward = w[9]^w[8], left = w[9], back = w[1]^w[0] and right = w[1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_ld_o | output | 1 | Capture strobe for the external shift register |
| ser_clk_o | output | 1 | Shift clock for the external shift register |
| ser_dat_i | input | 1 | Serial data from the external shift register |
| tst_we_i | input | 1 | Test write enable for all four counters |
| tst_dat_i | input | 16 | Test write data |
| port0_word_o | output | 16 | Port 0 positions (vertical high byte, horizontal low byte) |
| port1_word_o | output | 16 | Port 1 positions (vertical high byte, horizontal low byte) |
| port0_dir_o | output | 4 | Port 0 joystick directions {right, back, left, fwd} |
| port1_dir_o | output | 4 | Port 1 joystick directions {right, back, left, fwd} |
| ctrl_byte_o | output | 8 | Trailing eight frame bits |

## Verification
The bench drives more than 256 frames of steady forward motion on one axis and steady backward motion on another. A counter that fails to wrap, or that puts the carry on the wrong Gray transition, ends on a different final word. A third axis alternates between phases 0 and 2, so a design that treats that jump as a step drifts away from zero. One test write lands on the same edge as a frame that would carry, which exposes a wrong priority. The low bits of the test data are set to values different from the live phases, so a design that loads them corrupts the joystick view. A per-cycle reference model also catches any swapped bit in the serial order, any off-by-one in the update cycle and any misplaced control byte.

// File: rtl/mqc_pkg.sv
// Shared sizes and types for the serial-fed quadrature position counters.
// Assumes a frame of 8 quadrature bits followed by 8 control bits.
package mqc_pkg;
    localparam int QUAD_BITS  = 8;
    localparam int CTRL_BITS  = 8;
    localparam int FRAME_BITS = QUAD_BITS + CTRL_BITS;
    localparam int PH_W       = 2;
    localparam int HI_W       = 6;
    localparam int POS_W      = HI_W + PH_W;
    localparam int NAXIS      = 2;
    localparam int NPORT      = 2;
    localparam int WORD_W     = NAXIS * POS_W;
    localparam int PORT_BITS  = NAXIS * PH_W;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_LOAD  = 2'd1,
        SQ_SHIFT = 2'd2
    } seq_t;
endpackage

// File: rtl/ser_frame_rx.sv
// Drives the external parallel-to-serial register: a one-cycle capture
// strobe, then FRAME_BITS shift clock pulses of SCLK_HALF low and SCLK_HALF
// high cycles. Samples the data bit on the cycle the shift clock rises and
// stores it by arrival order. Pulses vld_o one cycle after the last sample.
// Assumes the external register shows bit 0 after capture and advances on
// each shift clock rise.
module ser_frame_rx
    import mqc_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic                  ld_o,
    output logic                  sclk_o,
    input  logic                  sdat_i,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic                  vld_o
);
    localparam int SUB_N = 2 * SCLK_HALF;
    localparam int SUB_W = (SUB_N > 2) ? $clog2(SUB_N) : 1;
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_N - 1);
    localparam logic [SUB_W-1:0] SUB_RISE = SUB_W'(SCLK_HALF - 1);
    localparam logic [SUB_W-1:0] SUB_HIGH = SUB_W'(SCLK_HALF);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

    seq_t                  state_q;
    logic [SUB_W-1:0]      sub_q;
    logic [IDX_W-1:0]      idx_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic                  done_q;
    logic                  sample;

    assign sample = (state_q == SQ_SHIFT) && (sub_q == SUB_RISE);
    assign ld_o   = (state_q == SQ_LOAD);
    assign sclk_o = (state_q == SQ_SHIFT) && (sub_q >= SUB_HIGH);

    // Frame sequencer: capture, then bit slots of low and high phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            sub_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: state_q <= SQ_LOAD;
                SQ_LOAD: begin
                    state_q <= SQ_SHIFT;
                    sub_q   <= '0;
                    idx_q   <= '0;
                end
                SQ_SHIFT: begin
                    if (sub_q == SUB_LAST) begin
                        sub_q <= '0;
                        if (idx_q == IDX_LAST) state_q <= SQ_LOAD;
                        else                   idx_q   <= idx_q + 1'b1;
                    end else begin
                        sub_q <= sub_q + 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Deserializer: store each sampled bit by arrival index, flag frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (sample) shreg_q[idx_q] <= sdat_i;
            done_q <= sample && (idx_q == IDX_LAST);
        end
    end

    assign frame_o = shreg_q;
    assign vld_o   = done_q;
endmodule

// File: rtl/quad_axis.sv
// One position value: a six-bit up/down counter over a two-bit Gray phase
// of a quadrature pair. The phase follows the pair on every update. The
// counter steps on a 3->0 (up) or 0->3 (down) phase change. A test load
// overrides the counter but never the phase.
// Assumes upd_i pulses once per completed frame.
module quad_axis
    import mqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic             main_i,
    input  logic             q_i,
    input  logic             ld_i,
    input  logic [HI_W-1:0]  ld_val_i,
    output logic [POS_W-1:0] pos_o
);
    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_new;
    logic [HI_W-1:0] cnt_q;
    logic            carry;
    logic            borrow;

    assign ph_new = {q_i, main_i ^ q_i};
    assign carry  = (ph_q == 2'd3) && (ph_new == 2'd0);
    assign borrow = (ph_q == 2'd0) && (ph_new == 2'd3);

    // Phase tracker: copy the Gray form of the pair at each frame.
    always_ff @(posedge clk) begin
        if (!rst_n)     ph_q <= '0;
        else if (upd_i) ph_q <= ph_new;
    end

    // Counter: test load first, otherwise single-step carry or borrow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
        end else if (upd_i) begin
            if (carry)       cnt_q <= cnt_q + 1'b1;
            else if (borrow) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pos_o = {cnt_q, ph_q};
endmodule

// File: rtl/joy_dir_dec.sv
// Reads a port word as a four-way switch: forward and left come from the
// vertical phase bits, back and right from the horizontal phase bits.
// Output order is {right, back, left, forward}. Purely combinational.
module joy_dir_dec
    import mqc_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [3:0]        dir_o
);
    logic fwd;
    logic lft;
    logic bck;
    logic rgt;
    logic [WORD_W-1:0] word_unused;

    assign lft = word_i[POS_W + 1];
    assign fwd = word_i[POS_W + 1] ^ word_i[POS_W];
    assign rgt = word_i[1];
    assign bck = word_i[1] ^ word_i[0];
    assign word_unused = word_i;
    assign dir_o = {rgt, bck, lft, fwd};
endmodule

// File: rtl/mouse_quad_ctr.sv
// Top: serial frame receiver, four quadrature position axes, two
// direction decoders and the control byte register.
// Assumes frame bits 0..7 carry main/quadrature pairs (h then v, port0
// then port1) and bits 8..15 carry the control byte.
module mouse_quad_ctr
    import mqc_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        ser_ld_o,
    output logic        ser_clk_o,
    input  logic        ser_dat_i,
    input  logic        tst_we_i,
    input  logic [15:0] tst_dat_i,
    output logic [15:0] port0_word_o,
    output logic [15:0] port1_word_o,
    output logic [3:0]  port0_dir_o,
    output logic [3:0]  port1_dir_o,
    output logic [7:0]  ctrl_byte_o
);
    logic [FRAME_BITS-1:0] frame;
    logic                  frame_vld;
    logic [POS_W-1:0]      pos  [NPORT][NAXIS];
    logic [WORD_W-1:0]     word [NPORT];
    logic [3:0]            dir  [NPORT];
    logic [CTRL_BITS-1:0]  ctrl_q;
    logic [3:0]            tst_unused;

    assign tst_unused = {tst_dat_i[9:8], tst_dat_i[1:0]};

    ser_frame_rx #(.SCLK_HALF(SCLK_HALF)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_o    (ser_ld_o),
        .sclk_o  (ser_clk_o),
        .sdat_i  (ser_dat_i),
        .frame_o (frame),
        .vld_o   (frame_vld)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        for (genvar a = 0; a < NAXIS; a++) begin : g_axis
            localparam int BASE = p * PORT_BITS + a * PH_W;
            localparam int LD_LSB = a * POS_W + PH_W;
            quad_axis u_axis (
                .clk      (clk),
                .rst_n    (rst_n),
                .upd_i    (frame_vld),
                .main_i   (frame[BASE]),
                .q_i      (frame[BASE + 1]),
                .ld_i     (tst_we_i),
                .ld_val_i (tst_dat_i[LD_LSB +: HI_W]),
                .pos_o    (pos[p][a])
            );
        end
        assign word[p] = {pos[p][1], pos[p][0]};
        joy_dir_dec u_dec (
            .word_i (word[p]),
            .dir_o  (dir[p])
        );
    end

    // Control byte: latch the trailing frame bits at each frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (frame_vld) ctrl_q <= frame[FRAME_BITS-1:QUAD_BITS];
    end

    assign port0_word_o = word[0];
    assign port1_word_o = word[1];
    assign port0_dir_o  = dir[0];
    assign port1_dir_o  = dir[1];
    assign ctrl_byte_o  = ctrl_q;
endmodule

// File: rtl/mouse_quad_ctr_chk.sv
// Property checker for mouse_quad_ctr: serial strobe shape, counter step
// size, test load effect and direction decode. Attached by bind below.
module mouse_quad_ctr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ld,
    input logic        sclk,
    input logic        tst_we,
    input logic [15:0] tst_dat,
    input logic [15:0] w0,
    input logic [15:0] w1,
    input logic [3:0]  d0,
    input logic [3:0]  d1
);
    logic [15:0] w0_prv;
    logic [15:0] w1_prv;
    logic [5:0]  s0v, s0h, s1v, s1h;
    logic        step_ok;

    // Previous word copies used to measure the counter step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w0_prv <= '0;
            w1_prv <= '0;
        end else begin
            w0_prv <= w0;
            w1_prv <= w1;
        end
    end

    assign s0v = w0[15:10] - w0_prv[15:10];
    assign s0h = w0[7:2]   - w0_prv[7:2];
    assign s1v = w1[15:10] - w1_prv[15:10];
    assign s1h = w1[7:2]   - w1_prv[7:2];
    assign step_ok = (s0v == 6'd0 || s0v == 6'd1 || s0v == 6'd63) &&
                     (s0h == 6'd0 || s0h == 6'd1 || s0h == 6'd63) &&
                     (s1v == 6'd0 || s1v == 6'd1 || s1v == 6'd63) &&
                     (s1h == 6'd0 || s1h == 6'd1 || s1h == 6'd63);

    // R2
    ld_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> !sclk);

    // R2
    ld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> !ld);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tst_we |=> step_ok);

    // R9
    test_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tst_we |=> (w0[15:10] == $past(tst_dat[15:10]) && w0[7:2] == $past(tst_dat[7:2]) &&
                    w1[15:10] == $past(tst_dat[15:10]) && w1[7:2] == $past(tst_dat[7:2])));

    // R12
    dir_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d0 == {w0[1], w0[1] ^ w0[0], w0[9], w0[9] ^ w0[8]}) &&
        (d1 == {w1[1], w1[1] ^ w1[0], w1[9], w1[9] ^ w1[8]}));
endmodule

bind mouse_quad_ctr mouse_quad_ctr_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (ser_ld_o),
    .sclk    (ser_clk_o),
    .tst_we  (tst_we_i),
    .tst_dat (tst_dat_i),
    .w0      (port0_word_o),
    .w1      (port1_word_o),
    .d0      (port0_dir_o),
    .d1      (port1_dir_o)
);

// File: tb/mouse_quad_ctr_bench.sv
module mouse_quad_ctr_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ser_ld_o, ser_clk_o;
    logic        ser_dat_i;
    logic        tst_we_i;
    logic [15:0] tst_dat_i;
    logic [15:0] port0_word_o, port1_word_o;
    logic [3:0]  port0_dir_o, port1_dir_o;
    logic [7:0]  ctrl_byte_o;

    always #4 clk = ~clk;

    mouse_quad_ctr u_mouse_quad_ctr (
        .clk(clk), .rst_n(rst_n), .ser_ld_o(ser_ld_o), .ser_clk_o(ser_clk_o),
        .ser_dat_i(ser_dat_i), .tst_we_i(tst_we_i), .tst_dat_i(tst_dat_i),
        .port0_word_o(port0_word_o), .port1_word_o(port1_word_o),
        .port0_dir_o(port0_dir_o), .port1_dir_o(port1_dir_o),
        .ctrl_byte_o(ctrl_byte_o)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // External shifter and reference model state
    logic [15:0] par_in = '0;
    logic [15:0] latch_v = '0;
    logic [15:0] done_v = '0;
    int  sh_idx = 0;
    int  rises = 0;
    bit  pending = 0;
    int  applied = 0;
    int  mcnt [2][2];
    int  mph  [2][2];
    int  mctrl = 0;
    int  nld = 0;
    time last_ld = 0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mword(input int p);
        return {6'(mcnt[p][1]), 2'(mph[p][1]), 6'(mcnt[p][0]), 2'(mph[p][0])};
    endfunction

    function automatic logic [3:0] mdir(input logic [15:0] w);
        return {w[1], w[1] ^ w[0], w[9], w[9] ^ w[8]};
    endfunction

    // Phase count c (0..3) to pair bits {q, main}
    function automatic logic [1:0] pair_of(input int c);
        logic [1:0] g;
        g = 2'(c);
        return {g[1], g[1] ^ g[0]};
    endfunction

    function automatic logic [15:0] mkframe(input int c0h, input int c0v,
                                            input int c1h, input int c1v,
                                            input logic [7:0] misc);
        return {misc, pair_of(c1v), pair_of(c1h), pair_of(c0v), pair_of(c0h)};
    endfunction

    // External register: capture on strobe
    always @(posedge ser_ld_o) begin
        #1;
        latch_v   = par_in;
        sh_idx    = 0;
        rises     = 0;
        ser_dat_i = latch_v[0];
    end

    // External register: advance on each shift clock rise
    always @(posedge ser_clk_o) begin
        rises++;
        if (rises == 16) begin
            done_v  = latch_v;
            pending = 1;
        end
        #1;
        sh_idx++;
        ser_dat_i = (sh_idx < 16) ? latch_v[sh_idx] : 1'b0;
    end

    // R2: frame shape seen at each strobe
    always @(posedge ser_ld_o) begin
        if (nld > 0) begin
            chk("R2 shift pulses per frame", 16'(rises), 16'd16);
            chk("R2 frame period cycles", 16'(($time - last_ld) / 8), 16'd65);
        end
        last_ld = $time;
        nld++;
    end

    // Reference model, advanced on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 2; p++)
                for (int a = 0; a < 2; a++) begin
                    mcnt[p][a] = 0;
                    mph[p][a]  = 0;
                end
            mctrl = 0;
        end else begin
            if (pending) begin
                for (int p = 0; p < 2; p++)
                    for (int a = 0; a < 2; a++) begin
                        int m, q, g, d;
                        m = int'(done_v[4*p + 2*a]);
                        q = int'(done_v[4*p + 2*a + 1]);
                        g = 2*q + (m ^ q);
                        d = (g - mph[p][a] + 4) % 4;
                        if (d == 1 && g == 0) mcnt[p][a] = (mcnt[p][a] + 1) % 64;
                        if (d == 3 && g == 3) mcnt[p][a] = (mcnt[p][a] + 63) % 64;
                        mph[p][a] = g;
                    end
                mctrl   = int'(done_v[15:8]);
                pending = 0;
                applied++;
            end
            if (tst_we_i) begin
                for (int p = 0; p < 2; p++) begin
                    mcnt[p][1] = int'(tst_dat_i[15:10]);
                    mcnt[p][0] = int'(tst_dat_i[7:2]);
                end
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 R4 R5 R6 port0 word", port0_word_o, mword(0));
            chk("R3 R4 R5 R6 port1 word", port1_word_o, mword(1));
            chk("R11 control byte", {8'h00, ctrl_byte_o}, 16'(mctrl));
            chk("R12 port0 dir", {12'h000, port0_dir_o}, {12'h000, mdir(mword(0))});
            chk("R12 port1 dir", {12'h000, port1_dir_o}, {12'h000, mdir(mword(1))});
        end
    end

    task automatic run_frame(input logic [15:0] v);
        int n;
        par_in = v;
        @(posedge ser_ld_o);
        n = applied;
        wait (applied == n + 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0001, 16'h0000);
        summary();
    end

    initial begin
        rst_n     = 1'b0;
        tst_we_i  = 1'b0;
        tst_dat_i = '0;
        ser_dat_i = 1'b0;
        repeat (5) @(negedge clk);
        // R1
        chk("R1 reset port0 word", port0_word_o, 16'h0000);
        chk("R1 reset port1 word", port1_word_o, 16'h0000);
        chk("R1 reset ctrl byte", {8'h00, ctrl_byte_o}, 16'h0000);
        chk("R1 reset dirs", {8'h00, port0_dir_o, port1_dir_o}, 16'h0000);
        chk("R1 reset strobes", {14'h0, ser_ld_o, ser_clk_o}, 16'h0000);
        rst_n = 1'b1;

        // R6 R7 R8: long forward / backward / two-step runs
        for (int s = 1; s <= 265; s++)
            run_frame(mkframe(s % 4, (4 - s % 4) % 4, (s % 2) * 2, 1, 8'(s)));
        @(negedge clk);
        chk("R7 R6 wrap port0 word", port0_word_o, 16'hF709);
        chk("R8 two-step port1 word", port1_word_o, 16'h0102);
        chk("R11 last control byte", {8'h00, ctrl_byte_o}, 16'h0009);
        chk("R12 port0 dir after run", {12'h000, port0_dir_o}, 16'h0006);

        // R9: test write, ignored bits differ from live phases
        tst_we_i  = 1'b1;
        tst_dat_i = 16'hA45F;
        @(negedge clk);
        tst_we_i  = 1'b0;
        chk("R9 test write port0", port0_word_o, 16'hA75D);
        chk("R9 test write port1", port1_word_o, 16'hA55E);

        // R10: test write on the same edge as a carrying frame
        run_frame(mkframe(2, 3, 2, 1, 8'h11));
        run_frame(mkframe(3, 3, 2, 1, 8'h22));
        par_in = mkframe(0, 3, 2, 1, 8'h3C);
        @(posedge ser_ld_o);
        wait (pending == 1);
        @(negedge clk);
        tst_we_i  = 1'b1;
        tst_dat_i = 16'h0C30;
        @(negedge clk);
        tst_we_i  = 1'b0;
        chk("R10 collision port0", port0_word_o, 16'h0F30);
        chk("R10 collision port1", port1_word_o, 16'h0D32);
        chk("R10 collision ctrl", {8'h00, ctrl_byte_o}, 16'h003C);

        // Mixed random frames and test writes
        for (int i = 0; i < 150; i++) begin
            run_frame(mkframe($urandom_range(3, 0), $urandom_range(3, 0),
                              $urandom_range(3, 0), $urandom_range(3, 0),
                              8'($urandom())));
            if ($urandom_range(7, 0) == 0) begin
                @(negedge clk);
                tst_we_i  = 1'b1;
                tst_dat_i = 16'($urandom());
                @(negedge clk);
                tst_we_i  = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        summary();
    end
endmodule